// File: doc/BRIEF.md
# Tuner Output Sample Formatter

This block is the last stage of a digital downconverter. It receives decimated complex baseband samples, one I/Q pair per accepted strobe, and shapes them into the stream that leaves the tuner. On the way it can mirror the spectrum by negating Q and move the spectrum by half the output rate by negating alternate output beats. It applies a two-part gain: a coarse power-of-two shift and a fine multiplier with steps of roughly 0.034 dB. The result is then rounded symmetrically to a selectable word size and clipped.

In complex mode each input pair produces one output beat that carries I and Q on two lanes, at up to one pair per clock. In real mode the pair is up-converted by a quarter of the real sample rate. It leaves as two successive real beats, so in this mode input pairs must be at least one idle cycle apart. The configuration inputs are static register values that change only while the pipeline is empty. A synchronous clear restarts the phase counters behind the alternating sequences.

Top module: `tuner_out_fmt`

## Requirements
- R1: In complex mode (`cfg_real`=0), a pair accepted at a clock edge appears at the output two edges later as one beat: I-derived value on `out_a`, Q-derived value on `out_b`, `out_qsel` low. Pairs on consecutive cycles come out on consecutive cycles.
- R2: In real mode (`cfg_real`=1), each pair gives two beats on consecutive cycles, the first two edges after acceptance. Across pairs since the last clear, the beats follow I, -Q, -I, Q, repeating. `out_qsel` is high on the Q-derived beat and `out_b` is zero. `in_valid` is never high on two consecutive cycles.
- R3: With `cfg_inv`=1, Q is negated before any other formatting, in both modes.
- R4: With `cfg_shift`=1, every odd-numbered output beat since the last clear is negated, counting from beat 0. In complex mode both lanes of the beat are negated.
- R5: A sample x is scaled to x*(256+`cfg_fine`)*2^`cfg_coarse` before word-length reduction.
- R6: `cfg_wsel` picks the output width W: 0 gives 10, 1 gives 12, 2 gives 14, 3 gives 16. The scaled value is divided by 2^(24-W) and the result is sign-extended onto the 16-bit output lanes.
- R7: Rounding is symmetric: magnitudes with a fraction of exactly one half round away from zero, so +x and -x give results of equal magnitude.
- R8: A rounded result above 2^(W-1)-1 becomes 2^(W-1)-1. A result below -2^(W-1) becomes -2^(W-1). Exactly -2^(W-1) passes unchanged.
- R9: `out_ovf` goes high with the first beat in which either lane is clipped. It stays high until `sync_clr` or reset.
- R10: A one-cycle `sync_clr` restarts the shift and real-mode sequences at beat 0 and pair 0, and clears `out_ovf`.
- R11: While reset is asserted, `out_valid`, `out_qsel` and `out_ovf` are low and both lanes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| sync_clr | input | 1 | Synchronous clear of sequence phases and overflow flag |
| cfg_real | input | 1 | 1 selects the real output stream, 0 the complex stream |
| cfg_inv | input | 1 | Spectral inversion (negate Q) |
| cfg_shift | input | 1 | Half-output-rate spectral shift |
| cfg_coarse | input | 3 | Coarse gain, left shift by 0..7 |
| cfg_fine | input | 8 | Fine gain G, multiplier (256+G)/256 |
| cfg_wsel | input | 2 | Output width select |
| in_valid | input | 1 | Input pair strobe |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output beat strobe |
| out_a | output | 16 | I lane (complex) or real sample, signed |
| out_b | output | 16 | Q lane (complex), zero in real mode |
| out_qsel | output | 1 | Real beat derived from Q |
| out_ovf | output | 1 | Sticky clipping flag |

## Verification
The bench targets the exact-half rounding point for both signs. A truncating or round-half-up design would return 0 or a lopsided -1 where +1/-1 is expected. It drives the largest negative input through a negation, where a design without a guard bit would wrap to -32768 instead of clipping to 32767. It also checks the limit code -512 at 10 bits, which an off-by-one clip would flag as overflow. Real mode is checked for the I, -Q, -I, Q order and for the second beat following the first on the very next cycle; a swapped or late beat changes the logged sequence. A clear issued in the middle of a stream must restart both phase counters: a stale counter shows up as a wrongly negated beat.

// File: rtl/tof_pkg.sv
`timescale 1ns/1ps
package tof_pkg;

  // Output width selector codes
  typedef enum logic [1:0] {
    WSEL_10 = 2'd0,
    WSEL_12 = 2'd1,
    WSEL_14 = 2'd2,
    WSEL_16 = 2'd3
  } wsel_e;

  // Width in bits for a selector code, relative to the widest output
  function automatic int unsigned width_bits(input logic [1:0] sel, input int unsigned max_w);
    return max_w - 32'd6 + 32'd2 * 32'(sel);
  endfunction

endpackage

// File: rtl/tof_seq.sv
`timescale 1ns/1ps
// Beat sequencer: inversion, half-rate shift and real-mode ordering.
module tof_seq #(
  parameter int IN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_clr,
  input  logic                 cfg_real,
  input  logic                 cfg_inv,
  input  logic                 cfg_shift,
  input  logic                 in_valid,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  output logic                 s_valid,
  output logic signed [IN_W:0] s_a,
  output logic signed [IN_W:0] s_b,
  output logic                 s_qsel
);

  localparam int XW = IN_W + 1;  // one guard bit so negating the most negative code stays exact

  logic signed [XW-1:0] ext_i, ext_q, q_adj, lead_val;
  logic signed [XW-1:0] a_n, b_n, pend_d_n;
  logic signed [XW-1:0] a_q, b_q, pend_d_q;
  logic                 v_n, v_q, qsel_n, qsel_q;
  logic                 pend_v_n, pend_v_q, pend_ld;
  logic                 oph_n, oph_q;    // output beat phase (shift)
  logic                 pph_n, pph_q;    // pair phase (real-mode order)
  logic                 neg_now;

  assign ext_i    = XW'(in_i);
  assign ext_q    = XW'(in_q);
  assign q_adj    = cfg_inv ? -ext_q : ext_q;
  assign lead_val = pph_q ? -ext_i : ext_i;
  assign neg_now  = cfg_shift & oph_q;

  // Next-state logic
  always_comb begin
    v_n      = 1'b0;
    a_n      = '0;
    b_n      = '0;
    qsel_n   = 1'b0;
    pend_v_n = pend_v_q;
    pend_d_n = pend_d_q;
    pend_ld  = 1'b0;
    oph_n    = oph_q;
    pph_n    = pph_q;
    if (pend_v_q) begin
      // second real beat of the held pair
      v_n      = 1'b1;
      a_n      = neg_now ? -pend_d_q : pend_d_q;
      qsel_n   = 1'b1;
      pend_v_n = 1'b0;
      oph_n    = ~oph_q;
    end else if (in_valid) begin
      v_n   = 1'b1;
      oph_n = ~oph_q;
      if (cfg_real) begin
        a_n      = neg_now ? -lead_val : lead_val;
        pend_v_n = 1'b1;
        pend_ld  = 1'b1;
        pend_d_n = pph_q ? q_adj : -q_adj;
        pph_n    = ~pph_q;
      end else begin
        a_n = neg_now ? -ext_i : ext_i;
        b_n = neg_now ? -q_adj : q_adj;
      end
    end
    if (sync_clr) begin
      pend_v_n = 1'b0;
      oph_n    = 1'b0;
      pph_n    = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q      <= 1'b0;
      qsel_q   <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      pend_v_q <= 1'b0;
      pend_d_q <= '0;
      oph_q    <= 1'b0;
      pph_q    <= 1'b0;
    end else begin
      v_q      <= v_n;
      qsel_q   <= qsel_n;
      pend_v_q <= pend_v_n;
      oph_q    <= oph_n;
      pph_q    <= pph_n;
      if (v_n) begin
        a_q <= a_n;
        b_q <= b_n;
      end
      if (pend_ld) begin
        pend_d_q <= pend_d_n;
      end
    end
  end

  assign s_valid = v_q;
  assign s_a     = a_q;
  assign s_b     = b_q;
  assign s_qsel  = qsel_q;

  // R2
  real_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_real && in_valid) |=> !in_valid);

endmodule

// File: rtl/tof_lane.sv
`timescale 1ns/1ps
// One lane: gain, symmetric rounding to the selected width, clipping.
module tof_lane #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 16,
  parameter int FINE_W  = 8,
  parameter int SHIFT_W = 3
) (
  input  logic signed [IN_W:0]      x,
  input  logic [FINE_W-1:0]         fine,
  input  logic [SHIFT_W-1:0]        coarse,
  input  logic [1:0]                wsel,
  output logic signed [OUT_W-1:0]   y,
  output logic                      sat
);

  localparam int XW     = IN_W + 1;
  localparam int PROD_W = XW + FINE_W + 1 + (2**SHIFT_W - 1) + 1;
  localparam int NSEL   = 4;

  logic signed [FINE_W+1:0]  gain_s;
  logic signed [PROD_W-1:0]  x_ext, g_ext, prod, scaled;
  logic [PROD_W-1:0]         mag;
  logic                      neg;
  logic [PROD_W-1:0]         rnd_w     [NSEL];
  logic [PROD_W-1:0]         pos_lim_w [NSEL];
  logic [PROD_W-1:0]         neg_lim_w [NSEL];
  logic [PROD_W-1:0]         rnd_sel, lim, clip;

  assign gain_s = {2'b01, fine};
  assign x_ext  = PROD_W'(x);
  assign g_ext  = PROD_W'(gain_s);
  assign prod   = x_ext * g_ext;
  assign scaled = prod <<< coarse;
  assign neg    = scaled[PROD_W-1];
  assign mag    = neg ? PROD_W'(-scaled) : PROD_W'(scaled);

  // One rounder per selectable width; the selector picks among them
  for (genvar k = 0; k < NSEL; k++) begin : g_w
    localparam int W = OUT_W - 6 + 2 * k;
    localparam int R = FINE_W + IN_W - W;
    assign rnd_w[k]     = (mag + (PROD_W'(1) << (R - 1))) >> R;
    assign neg_lim_w[k] = PROD_W'(1) << (W - 1);
    assign pos_lim_w[k] = (PROD_W'(1) << (W - 1)) - PROD_W'(1);
  end

  always_comb begin
    rnd_sel = rnd_w[wsel];
    lim     = neg ? neg_lim_w[wsel] : pos_lim_w[wsel];
    sat     = rnd_sel > lim;
    clip    = sat ? lim : rnd_sel;
    y       = neg ? OUT_W'(-clip) : OUT_W'(clip);
  end

endmodule

// File: rtl/tuner_out_fmt.sv
`timescale 1ns/1ps
// Tuner output formatter top: sequencer, two arithmetic lanes, output register.
module tuner_out_fmt #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 16,
  parameter int FINE_W  = 8,
  parameter int SHIFT_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sync_clr,
  input  logic                      cfg_real,
  input  logic                      cfg_inv,
  input  logic                      cfg_shift,
  input  logic [SHIFT_W-1:0]        cfg_coarse,
  input  logic [FINE_W-1:0]         cfg_fine,
  input  logic [1:0]                cfg_wsel,
  input  logic                      in_valid,
  input  logic signed [IN_W-1:0]    in_i,
  input  logic signed [IN_W-1:0]    in_q,
  output logic                      out_valid,
  output logic signed [OUT_W-1:0]   out_a,
  output logic signed [OUT_W-1:0]   out_b,
  output logic                      out_qsel,
  output logic                      out_ovf
);

  import tof_pkg::*;

  localparam int XW    = IN_W + 1;
  localparam int LANES = 2;

  logic                    s_valid, s_qsel;
  logic signed [XW-1:0]    s_a, s_b;
  logic signed [XW-1:0]    lane_x   [LANES];
  logic signed [OUT_W-1:0] lane_y   [LANES];
  logic [LANES-1:0]        lane_sat;

  tof_seq #(.IN_W(IN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_clr  (sync_clr),
    .cfg_real  (cfg_real),
    .cfg_inv   (cfg_inv),
    .cfg_shift (cfg_shift),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .s_valid   (s_valid),
    .s_a       (s_a),
    .s_b       (s_b),
    .s_qsel    (s_qsel)
  );

  assign lane_x[0] = s_a;
  assign lane_x[1] = s_b;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tof_lane #(
      .IN_W    (IN_W),
      .OUT_W   (OUT_W),
      .FINE_W  (FINE_W),
      .SHIFT_W (SHIFT_W)
    ) u_lane (
      .x      (lane_x[l]),
      .fine   (cfg_fine),
      .coarse (cfg_coarse),
      .wsel   (cfg_wsel),
      .y      (lane_y[l]),
      .sat    (lane_sat[l])
    );
  end

  // Output stage next state
  logic ovf_n, ovf_q;
  logic vout_q, qsel_q;
  logic signed [OUT_W-1:0] a_q, b_q;

  always_comb begin
    ovf_n = ovf_q | (s_valid & (|lane_sat));
    if (sync_clr) ovf_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout_q <= 1'b0;
      qsel_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      ovf_q  <= 1'b0;
    end else begin
      vout_q <= s_valid;
      qsel_q <= s_qsel;
      ovf_q  <= ovf_n;
      if (s_valid) begin
        a_q <= lane_y[0];
        b_q <= lane_y[1];
      end
    end
  end

  assign out_valid = vout_q;
  assign out_qsel  = qsel_q;
  assign out_a     = a_q;
  assign out_b     = b_q;
  assign out_ovf   = ovf_q;

  // Limits of the currently selected width, used by the range check
  int unsigned cur_w;
  int          lim_hi, lim_lo;
  assign cur_w  = width_bits(cfg_wsel, OUT_W);
  assign lim_hi = (1 <<< (cur_w - 1)) - 1;
  assign lim_lo = -(1 <<< (cur_w - 1));

  // R1
  cplx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_real) |-> ##2 out_valid);

  // R2
  real_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_qsel && cfg_real) |=> (out_valid && out_qsel));

  // R8
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_a) <= lim_hi && int'(out_a) >= lim_lo &&
                   int'(out_b) <= lim_hi && int'(out_b) >= lim_lo));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ovf && !sync_clr) |=> out_ovf);

endmodule

// File: tb/sim_tuner_out_fmt.sv
`timescale 1ns/1ps
module sim_tuner_out_fmt;

  logic clk, rst_n, sync_clr;
  logic cfg_real, cfg_inv, cfg_shift;
  logic [2:0] cfg_coarse;
  logic [7:0] cfg_fine;
  logic [1:0] cfg_wsel;
  logic in_valid;
  logic signed [15:0] in_i, in_q;
  logic out_valid, out_qsel, out_ovf;
  logic signed [15:0] out_a, out_b;

  tuner_out_fmt u0 (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr),
    .cfg_real(cfg_real), .cfg_inv(cfg_inv), .cfg_shift(cfg_shift),
    .cfg_coarse(cfg_coarse), .cfg_fine(cfg_fine), .cfg_wsel(cfg_wsel),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
    .out_qsel(out_qsel), .out_ovf(out_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Output log, filled away from the active edge
  int log_n = 0;
  logic signed [15:0] log_a [64];
  logic signed [15:0] log_b [64];
  logic               log_q [64];
  int                 log_t [64];
  always @(negedge clk) begin
    if (out_valid && log_n < 64) begin
      log_a[log_n] = out_a;
      log_b[log_n] = out_b;
      log_q[log_n] = out_q_or();
      log_t[log_n] = cyc;
      log_n = log_n + 1;
    end
  end
  function automatic logic out_q_or();
    return out_qsel;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_beat(input int idx, input int ea, input int eb, input int eq, input string req);
    chk(idx < log_n, req, log_n, idx + 1);
    if (idx < log_n) begin
      chk(int'(log_a[idx]) == ea, req, int'(log_a[idx]), ea);
      chk(int'(log_b[idx]) == eb, req, int'(log_b[idx]), eb);
      chk(int'(log_q[idx]) == eq, req, int'(log_q[idx]), eq);
    end
  endtask

  task automatic send(input int i, input int q);
    in_valid = 1'b1;
    in_i = 16'(i);
    in_q = 16'(q);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
  endtask

  task automatic set_cfg(input bit r, input bit inv, input bit sh, input int c, input int f, input int w);
    cfg_real = r; cfg_inv = inv; cfg_shift = sh;
    cfg_coarse = 3'(c); cfg_fine = 8'(f); cfg_wsel = 2'(w);
  endtask

  typedef struct packed {
    logic               inv;
    logic [2:0]         c;
    logic [7:0]         f;
    logic [1:0]         w;
    logic signed [15:0] i;
    logic signed [15:0] q;
    logic signed [15:0] ea;
    logic signed [15:0] eb;
    logic               eo;
  } vec_t;

  // Complex mode, shift off; expected lanes and sticky flag after each row
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 8'd0,   2'd3, 16'sd1000,   -16'sd2000, 16'sd1000,   -16'sd2000,  1'b0}, // R5 unity
    '{1'b1, 3'd0, 8'd0,   2'd3, 16'sd1000,   -16'sd2000, 16'sd1000,   16'sd2000,   1'b0}, // R3
    '{1'b0, 3'd0, 8'd0,   2'd0, 16'sd1000,   -16'sd2000, 16'sd16,     -16'sd31,    1'b0}, // R6 10 bit
    '{1'b0, 3'd0, 8'd0,   2'd2, 16'sd2,      -16'sd2,    16'sd1,      -16'sd1,     1'b0}, // R7 half
    '{1'b0, 3'd0, 8'd0,   2'd2, 16'sd6,      -16'sd1,    16'sd2,      16'sd0,      1'b0}, // R7 1.5, -0.25
    '{1'b0, 3'd7, 8'd0,   2'd3, 16'sd300,    -16'sd300,  16'sd32767,  -16'sd32768, 1'b1}, // R8 both rails
    '{1'b0, 3'd0, 8'd128, 2'd3, 16'sd100,    -16'sd3,    16'sd150,    -16'sd5,     1'b1}, // R5 fine, R9 held
    '{1'b0, 3'd1, 8'd255, 2'd1, 16'sd1000,   16'sd0,     16'sd250,    16'sd0,      1'b1}, // R5 R6 12 bit
    '{1'b1, 3'd0, 8'd0,   2'd3, -16'sd32768, 16'sd32767, -16'sd32768, -16'sd32767, 1'b1}, // R3 extremes
    '{1'b0, 3'd0, 8'd0,   2'd0, -16'sd32768, 16'sd32767, -16'sd512,   16'sd511,    1'b1}  // R8 10-bit limits
  };

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    int t0;
    rst_n = 1'b0; sync_clr = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    set_cfg(0, 0, 0, 0, 0, 3);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11", int'(out_valid), 0);
    chk(out_ovf == 1'b0 && out_qsel == 1'b0, "R11", int'(out_ovf), 0);
    chk(out_a == 16'sd0 && out_b == 16'sd0, "R11", int'(out_a), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      set_cfg(0, VECS[k].inv, 0, int'(VECS[k].c), int'(VECS[k].f), int'(VECS[k].w));
      base = log_n;
      send(int'(VECS[k].i), int'(VECS[k].q));
      settle();
      chk(log_n == base + 1, "R1", log_n - base, 1);
      chk_beat(base, int'(VECS[k].ea), int'(VECS[k].eb), 0, $sformatf("R5/R6/R7/R8 row %0d", k));
      chk(out_ovf == VECS[k].eo, "R9", int'(out_ovf), int'(VECS[k].eo));
    end

    // R9 R10: clear drops the sticky flag
    pulse_clr();
    #1;
    chk(out_ovf == 1'b0, "R10", int'(out_ovf), 0);

    // R1: full-rate burst with latency and spacing
    set_cfg(0, 0, 0, 0, 0, 3);
    @(negedge clk);
    base = log_n;
    t0 = cyc;
    send(1, 2); send(3, 4); send(5, 6); send(7, 8);
    settle();
    chk(log_n == base + 4, "R1", log_n - base, 4);
    for (int k = 0; k < 4; k++) begin
      chk_beat(base + k, 2 * k + 1, 2 * k + 2, 0, "R1");
      chk(log_t[base + k] == t0 + 2 + k, "R1", log_t[base + k], t0 + 2 + k);
    end

    // R4: complex shift, with a negated most-negative input that must clip (R8)
    pulse_clr();
    set_cfg(0, 0, 1, 0, 0, 3);
    base = log_n;
    send(10, 20); send(30, 40); send(50, 60); send(-32768, 5);
    settle();
    chk_beat(base,     10,    20,  0, "R4");
    chk_beat(base + 1, -30,   -40, 0, "R4");
    chk_beat(base + 2, 50,    60,  0, "R4");
    chk_beat(base + 3, 32767, -5,  0, "R4 R8");
    chk(out_ovf == 1'b1, "R9", int'(out_ovf), 1);

    // R10: clear in mid-stream restarts the shift phase
    base = log_n;
    send(1, 1);
    settle();
    pulse_clr();
    send(2, 3);
    settle();
    chk_beat(base,     1, 1, 0, "R10");
    chk_beat(base + 1, 2, 3, 0, "R10");

    // R2: real mode order, qsel, zero B lane, back-to-back beats
    pulse_clr();
    set_cfg(1, 0, 0, 0, 0, 3);
    base = log_n;
    send(10, 20); @(negedge clk);
    send(30, 40); @(negedge clk);
    send(50, 60); @(negedge clk);
    send(70, 80);
    settle();
    chk(log_n == base + 8, "R2", log_n - base, 8);
    chk_beat(base,     10,  0, 0, "R2");
    chk_beat(base + 1, -20, 0, 1, "R2");
    chk_beat(base + 2, -30, 0, 0, "R2");
    chk_beat(base + 3, 40,  0, 1, "R2");
    chk_beat(base + 4, 50,  0, 0, "R2");
    chk_beat(base + 5, -60, 0, 1, "R2");
    chk_beat(base + 6, -70, 0, 0, "R2");
    chk_beat(base + 7, 80,  0, 1, "R2");
    chk(log_t[base + 1] == log_t[base] + 1, "R2", log_t[base + 1], log_t[base] + 1);

    // R4 in real mode
    pulse_clr();
    set_cfg(1, 0, 1, 0, 0, 3);
    base = log_n;
    send(10, 20); @(negedge clk);
    send(30, 40);
    settle();
    chk_beat(base,     10,  0, 0, "R4");
    chk_beat(base + 1, 20,  0, 1, "R4");
    chk_beat(base + 2, -30, 0, 0, "R4");
    chk_beat(base + 3, -40, 0, 1, "R4");

    // R3 in real mode
    pulse_clr();
    set_cfg(1, 1, 0, 0, 0, 3);
    base = log_n;
    send(10, 20); @(negedge clk);
    send(30, 40);
    settle();
    chk_beat(base + 1, 20,  0, 1, "R3");
    chk_beat(base + 3, -40, 0, 1, "R3");

    // R10: clear restarts the real-mode pair order
    pulse_clr();
    set_cfg(1, 0, 0, 0, 0, 3);
    base = log_n;
    send(1, 2);
    settle();
    pulse_clr();
    send(3, 4);
    settle();
    chk_beat(base,     1,  0, 0, "R10");
    chk_beat(base + 2, 3,  0, 0, "R10");
    chk_beat(base + 3, -4, 0, 1, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule